// File: doc/BRIEF.md
# Scan-Chain Circuit with Stuck-At Fault Injection

This block is a small sequential circuit that already carries scan: four mux-D flops, a three-input AND stage that feeds a capture flop, and an XOR stage that drives a functional output. With scan enable high, the scan flops form one serial chain from the scan-in pin to the scan-out pin. With scan enable low, every flop captures its functional input. The block serves as a device under test when scan-based test flows are exercised: a tester loads a pattern, captures once, and unloads the response.

A runtime fault selector can tie one pin of one gate to a constant 0 or 1. The selector can pick either input or the output of either gate, so each gate offers six stuck-at sites. Two elaboration parameters shape the chain. The first fixes the order in which flops are stitched. The second marks some flops as non-scan; those flops keep plain D behaviour and the chain skips them.

Top module: `scanfi_core`

## Requirements
- R1: While `rst_n` is low, every flop is 0 whatever `scan_en` is, so `scan_out` is 0 and, with no fault selected, `func_out` is 0.
- R2: With `scan_en`=1, each scan flop loads the Q of the scan flop before it in the chain (the first loads `scan_in`), one bit per clock. In the default chain (scan_in → flop0 → flop1 → flop2 → flop3 → scan_out), a bit presented at `scan_in` shows on `scan_out` after exactly 4 rising edges.
- R3: With `scan_en`=0, flop i (i = 0..2) captures `func_in[i]` and flop3 captures a = flop0, b = flop1, c = flop2 passed through out = b AND c (gate 0: input 0 = flop1, input 1 = flop2).
- R4: `func_out` equals flop0 XOR flop3 at all times (gate 1: input 0 = flop0, input 1 = flop3).
- R5: `fault_sel` value 0 selects no fault, and values 13 to 15 also select no fault. A value k in 1..12 selects a site with j = k-1: the stuck value is j mod 2, the pin is (j/2) mod 3 (0 = input 0, 1 = input 1, 2 = output), and the gate is j/6. At most one pin is forced at a time.
- R6: A selected fault replaces the value at that single pin with the stuck value. A fault on an input pin changes only what that gate sees.
- R7: With `fault_sel`=5 (gate 0 output stuck at 0), the captured flop3 value differs from the fault-free value only for the (a,b,c) patterns 011 and 111.
- R8: A flop marked non-scan (its `SCAN_MASK` bit 0) captures its functional input on every clock, even while `scan_en`=1.
- R9: The chain skips non-scan flops and follows `CHAIN_ORDER`. Chain position p holds the flop index in bits [2p+1:2p]. `scan_out` is the Q of the last scan flop in that order.
- R10: Reset is asserted asynchronously and released through a two-stage synchronizer. The first two rising edges after `rst_n` rises leave every flop at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1 = shift along the chain, 0 = functional capture |
| scan_in | input | 1 | Serial data into the first scan flop |
| func_in | input | 3 | Functional D inputs of flops 0..2 |
| fault_sel | input | 4 | Encoded stuck-at site and value, 0 = no fault |
| scan_out | output | 1 | Q of the last scan flop in the chain |
| func_out | output | 1 | Functional output, flop0 XOR flop3 |

## Verification
The hardest state to reach from the ports is a non-scan flop holding a chosen value at the moment of capture. No serial path reaches that flop, so the only control is its functional input, and that input is sampled on every edge, including shift edges. The bench uses a second instance with a reversed order and one flop marked non-scan. It holds that flop's functional input steady during the whole load, then captures and unloads through the reordered chain. The response shows both the skipped flop's value and the stitching order.

// File: rtl/scanfi_pkg.sv
package scanfi_pkg;

  localparam int NFF   = 4;              // flops in the circuit
  localparam int IW    = $clog2(NFF);    // bits per chain-order entry
  localparam int NGATE = 2;              // fault-capable gates
  localparam int NPIN  = 3;              // pins per gate: in0, in1, out
  localparam int NSITE = NGATE * NPIN * 2;
  localparam int FSW   = $clog2(NSITE + 1);
  localparam int GW    = (NGATE > 1) ? $clog2(NGATE) : 1;

  typedef enum logic { GK_AND, GK_XOR } gate_kind_e;

  typedef struct packed {
    logic          act;
    logic [GW-1:0] gate;
    logic [1:0]    pin;
    logic          val;
  } fault_t;

  function automatic fault_t decode_fault(input logic [FSW-1:0] code);
    fault_t f;
    int unsigned k;
    f = '0;
    k = 0;
    if ((code != '0) && (int'(code) <= NSITE)) begin
      k      = int'(code) - 1;
      f.act  = 1'b1;
      f.val  = k[0];
      f.pin  = 2'((k / 2) % NPIN);
      f.gate = GW'(k / (2 * NPIN));
    end
    return f;
  endfunction

  function automatic int pos_of(input logic [NFF*IW-1:0] order, input int fl);
    for (int p = 0; p < NFF; p++)
      if (int'(order[p*IW +: IW]) == fl) return p;
    return -1;
  endfunction

  function automatic int chain_pred(input logic [NFF*IW-1:0] order,
                                    input logic [NFF-1:0]    mask,
                                    input int                fl);
    int p;
    int c;
    p = pos_of(order, fl);
    for (int s = p - 1; s >= 0; s--) begin
      c = int'(order[s*IW +: IW]);
      if (mask[c]) return c;
    end
    return -1;
  endfunction

  function automatic int chain_last(input logic [NFF*IW-1:0] order,
                                    input logic [NFF-1:0]    mask);
    int c;
    for (int s = NFF - 1; s >= 0; s--) begin
      c = int'(order[s*IW +: IW]);
      if (mask[c]) return c;
    end
    return -1;
  endfunction

endpackage

// File: rtl/scanfi_rst_sync.sv
module scanfi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sr_q <= '0;
    else           sr_q <= sr_d;
  end

  assign rst_n_out = sr_q[STAGES-1];

endmodule

// File: rtl/scanfi_cell.sv
module scanfi_cell #(
  parameter bit IS_SCAN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic d,
  input  logic si,
  output logic q
);

  logic nxt;

  generate
    if (IS_SCAN) begin : g_mux
      always_comb nxt = se ? si : d;
    end else begin : g_plain
      logic unused_si;
      always_comb begin
        unused_si = si ^ se;
        nxt       = d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end

  // R2: a scan flop in shift mode takes its serial neighbour
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SCAN && se) |=> (q == $past(si)));

  // R3 / R8: capture mode, or any non-scan flop, takes the functional input
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(IS_SCAN && se) |=> (q == $past(d)));

endmodule

// File: rtl/scanfi_gate.sv
module scanfi_gate
  import scanfi_pkg::*;
#(
  parameter gate_kind_e KIND = GK_AND
) (
  input  logic            in0,
  input  logic            in1,
  input  logic [NPIN-1:0] force_pin,
  input  logic            force_val,
  output logic            y
);

  logic a0;
  logic a1;
  logic raw;

  always_comb begin
    a0  = force_pin[0] ? force_val : in0;
    a1  = force_pin[1] ? force_val : in1;
    raw = (KIND == GK_AND) ? (a0 & a1) : (a0 ^ a1);
    y   = force_pin[2] ? force_val : raw;
  end

endmodule

// File: rtl/scanfi_core.sv
module scanfi_core
  import scanfi_pkg::*;
#(
  parameter logic [NFF*IW-1:0] CHAIN_ORDER = {2'd3, 2'd2, 2'd1, 2'd0},
  parameter logic [NFF-1:0]    SCAN_MASK   = '1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_en,
  input  logic           scan_in,
  input  logic [NFF-2:0] func_in,
  input  logic [FSW-1:0] fault_sel,
  output logic           scan_out,
  output logic           func_out
);

  localparam int LAST = chain_last(CHAIN_ORDER, SCAN_MASK);

  logic                  rst_int;
  fault_t                flt;
  logic [NGATE*NPIN-1:0] force_vec;
  logic [NFF-1:0]        q;
  logic [NFF-1:0]        d;
  logic [NFF-1:0]        si;
  logic                  and_y;
  logic                  xor_y;

  scanfi_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int)
  );

  always_comb flt = decode_fault(fault_sel);

  generate
    for (genvar g = 0; g < NGATE; g++) begin : g_site_gate
      for (genvar p = 0; p < NPIN; p++) begin : g_site_pin
        assign force_vec[g*NPIN+p] = flt.act && (int'(flt.gate) == g)
                                     && (int'(flt.pin) == p);
      end
    end
  endgenerate

  // three-input stage: a = q[0] unused here, b = q[1], c = q[2]
  scanfi_gate #(.KIND(GK_AND)) and_gate_i (
    .in0       (q[1]),
    .in1       (q[2]),
    .force_pin (force_vec[0 +: NPIN]),
    .force_val (flt.val),
    .y         (and_y)
  );

  scanfi_gate #(.KIND(GK_XOR)) xor_gate_i (
    .in0       (q[0]),
    .in1       (q[NFF-1]),
    .force_pin (force_vec[NPIN +: NPIN]),
    .force_val (flt.val),
    .y         (xor_y)
  );

  assign d = {and_y, func_in};

  generate
    for (genvar i = 0; i < NFF; i++) begin : g_ff
      localparam int PRED = chain_pred(CHAIN_ORDER, SCAN_MASK, i);
      if (PRED < 0) begin : g_head
        assign si[i] = scan_in;
      end else begin : g_link
        assign si[i] = q[PRED];
      end
      scanfi_cell #(.IS_SCAN(SCAN_MASK[i])) cell_i (
        .clk   (clk),
        .rst_n (rst_int),
        .se    (scan_en),
        .d     (d[i]),
        .si    (si[i]),
        .q     (q[i])
      );
    end
    if (LAST >= 0) begin : g_so
      assign scan_out = q[LAST];
    end else begin : g_so_none
      assign scan_out = scan_in;
    end
  endgenerate

  assign func_out = xor_y;

  // R1 / R10: flops stay cleared on the edge after reset was still held
  p_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int |=> (q == '0));

  // R5: at most one gate pin forced
  p_one_site_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(force_vec));

  // R7: gate 0 output stuck at 0 presents 0 to the capture flop
  p_and_sa0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sel == FSW'(5)) |-> !d[NFF-1]);

endmodule

// File: tb/scanfi_core_tb_top.sv
module scanfi_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_en;
  logic       scan_in;
  logic [2:0] func_in;
  logic [3:0] fault_sel;
  logic       scan_out;
  logic       func_out;
  logic       scan_out2;
  logic       func_out2;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  scanfi_core dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_in(func_in), .fault_sel(fault_sel),
    .scan_out(scan_out), .func_out(func_out)
  );

  // reversed order, flop1 non-scan: scan_in -> f3 -> f2 -> f0 -> scan_out
  scanfi_core #(
    .CHAIN_ORDER({2'd0, 2'd1, 2'd2, 2'd3}),
    .SCAN_MASK  (4'b1101)
  ) dut_ns_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_in(func_in), .fault_sel(fault_sel),
    .scan_out(scan_out2), .func_out(func_out2)
  );

  // [19:16] fault code, [15:12] load {q3,q2,q1,q0}, [11:9] func_in,
  // [8:5] unload {q3,q2,q1,q0}, [4] func_out after load, [3:0] requirement
  localparam int NV = 12;
  localparam logic [19:0] VECS [NV] = '{
    {4'd0,  4'b0110, 3'b101, 4'b1101, 1'b0, 4'd3},  // R3
    {4'd5,  4'b0110, 3'b101, 4'b0101, 1'b0, 4'd6},  // R6 and out sa0
    {4'd6,  4'b0000, 3'b000, 4'b1000, 1'b0, 4'd6},  // R6 and out sa1
    {4'd1,  4'b0110, 3'b010, 4'b0010, 1'b0, 4'd6},  // R6 and in0 sa0
    {4'd4,  4'b0010, 3'b111, 4'b1111, 1'b0, 4'd6},  // R6 and in1 sa1
    {4'd2,  4'b0100, 3'b000, 4'b1000, 1'b0, 4'd6},  // R6 and in0 sa1
    {4'd0,  4'b1001, 3'b011, 4'b0011, 1'b0, 4'd4},  // R4
    {4'd7,  4'b1001, 3'b000, 4'b0000, 1'b1, 4'd5},  // R5 xor in0 sa0
    {4'd12, 4'b0000, 3'b110, 4'b0110, 1'b1, 4'd5},  // R5 xor out sa1
    {4'd11, 4'b0001, 3'b001, 4'b0001, 1'b0, 4'd5},  // R5 xor out sa0
    {4'd10, 4'b0000, 3'b100, 4'b0100, 1'b1, 4'd5},  // R5 xor in1 sa1
    {4'd14, 4'b0110, 3'b000, 4'b1000, 1'b0, 4'd5}   // R5 unused code
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load4(input logic [3:0] l);
    for (int i = 3; i >= 0; i--) begin
      scan_en = 1'b1;
      scan_in = l[i];
      tick();
    end
  endtask

  task automatic capture(input logic [2:0] fin);
    scan_en = 1'b0;
    func_in = fin;
    tick();
    scan_en = 1'b1;
    scan_in = 1'b0;
  endtask

  task automatic unload4(output logic [3:0] u);
    u[3] = scan_out;
    for (int i = 2; i >= 0; i--) begin
      tick();
      u[i] = scan_out;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] u;
    logic [19:0] v;
    rst_n     = 1'b0;
    scan_en   = 1'b1;
    scan_in   = 1'b1;
    func_in   = 3'b111;
    fault_sel = 4'd0;
    @(negedge clk);
    repeat (4) tick();

    // R1: held in reset with shift active and ones at scan_in
    chk("R1 scan_out in reset", 8'(scan_out), 8'd0);
    chk("R1 func_out in reset", 8'(func_out), 8'd0);
    chk("R1 second instance in reset", 8'(scan_out2), 8'd0);

    // R10: release, first two edges ignored, then 4 shifts reach scan_out
    rst_n = 1'b1;
    repeat (5) tick();
    chk("R10 scan_out after 5 edges", 8'(scan_out), 8'd0);
    tick();
    chk("R10 scan_out after 6 edges", 8'(scan_out), 8'd1);

    // R2: a single one walks the default chain in 4 edges
    load4(4'b0000);
    scan_in = 1'b1;
    tick();
    scan_in = 1'b0;
    tick(); tick();
    chk("R2 bit not yet out at 3 edges", 8'(scan_out), 8'd0);
    tick();
    chk("R2 bit out at 4 edges", 8'(scan_out), 8'd1);
    tick();
    chk("R2 bit gone at 5 edges", 8'(scan_out), 8'd0);

    // table: R3 R4 R5 R6
    for (int n = 0; n < NV; n++) begin
      v = VECS[n];
      fault_sel = v[19:16];
      load4(v[15:12]);
      chk($sformatf("R%0d row %0d func_out", v[3:0], n), 8'(func_out), 8'(v[4]));
      capture(v[11:9]);
      unload4(u);
      chk($sformatf("R%0d row %0d unload", v[3:0], n), 8'(u), 8'(v[8:5]));
    end

    // R7: (a,b,c) = (q0,q1,q2) swept, capture flop read right after capture
    for (int p = 0; p < 8; p++) begin
      logic a, b, c, good, bad;
      a = p[2]; b = p[1]; c = p[0];
      fault_sel = 4'd0;
      load4({1'b0, c, b, a});
      capture(3'b000);
      good = scan_out;
      fault_sel = 4'd5;
      load4({1'b0, c, b, a});
      capture(3'b000);
      bad = scan_out;
      chk($sformatf("R7 fault-free abc=%0d%0d%0d", a, b, c), 8'(good), 8'(b & c));
      chk($sformatf("R7 differs abc=%0d%0d%0d", a, b, c), 8'(good ^ bad), 8'(b & c));
    end
    fault_sel = 4'd0;

    // R8 R9: non-scan flop1 held by func_in[1] during shift
    for (int t = 0; t < 2; t++) begin
      logic f1;
      f1 = (t == 0);
      func_in = {1'b0, f1, 1'b0};
      scan_en = 1'b1;
      scan_in = 1'b0; tick();   // ends in f0
      scan_in = 1'b1; tick();   // ends in f2
      scan_in = 1'b0; tick();   // ends in f3
      capture(3'b000);
      chk("R9 scan_out is flop0", 8'(scan_out2), 8'd0);
      tick();
      chk("R9 second bit is flop2", 8'(scan_out2), 8'd0);
      tick();
      chk($sformatf("R8 capture of non-scan flop f1=%0d", f1), 8'(scan_out2), 8'(f1));
    end

    // R9: three-flop chain, one appears after 3 edges
    func_in = 3'b000;
    scan_in = 1'b0;
    repeat (3) tick();
    scan_in = 1'b1;
    tick();
    scan_in = 1'b0;
    tick();
    chk("R9 short chain at 2 edges", 8'(scan_out2), 8'd0);
    tick();
    chk("R9 short chain at 3 edges", 8'(scan_out2), 8'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule